// File: doc/BRIEF.md
# Double-Buffered Timer Channel Value Register

This block holds the value register of one timer channel. Software writes the value one byte at a time over a narrow bus. Each byte lands in a holding buffer first. The active register changes only when the channel mode and the timer clock state allow it. The active register is what the rest of the timer compares against. Software reads it back directly, so polling until the readback equals the written value confirms that the new value has taken effect.

The commit timing depends on the channel mode:

- **Input capture:** software writes have no effect. A capture event copies the running counter into the active register.
- **Output compare:** a completed byte pair waits for the next prescaler tick.
- **Edge-aligned PWM:** a completed byte pair waits for the counter overflow, so the duty value changes only on a period boundary.
- **Timer clock stopped:** a completed pair commits at once.

A write to the channel's status/control register withdraws any pending update and discards partly collected bytes.

Top module: `tmr_chan_value`

## Requirements
- R1: After reset, `val` is zero and `pending` is low.
- R2: With `mode` = 2'b00 (input capture), byte writes change neither `val` nor `pending`, and they leave no byte in the collector: a later single byte written in another mode does not complete a pair.
- R3: With `mode` = 2'b00, a cycle with `cap_evt` high loads `cnt_val` into `val` at that clock edge. In any other mode `cap_evt` has no effect.
- R4: With `clk_on` low and a non-capture mode, the write that completes a byte pair updates `val` at that same clock edge, and `pending` stays low. The bytes may arrive in either order (`wr_sel` = 1 selects bits 15:8, `wr_sel` = 0 selects bits 7:0).
- R5: With `mode` = 2'b01 (output compare) and `clk_on` high, completing a pair raises `pending`. The first `presc_tick` in a later cycle commits the value and clears `pending`. `ovf_tick` alone does nothing.
- R6: With `mode` = 2'b10 (edge-aligned PWM) and `clk_on` high, a pending value commits only on `ovf_tick`. `presc_tick` alone does nothing.
- R7: `pending` rises only once every byte lane has been written since the last commit or cancel. Rewriting the same lane does not complete a pair.
- R8: `ctrl_wr` clears `pending` without committing and discards collected bytes. It wins over a tick in the same cycle.
- R9: A byte write while `pending` is high withdraws the pending value and starts a new pair with that byte. It wins over a tick in the same cycle.
- R10: If `clk_on` is low in a cycle while `pending` is high, the buffered value commits at that edge.
- R11: Entering input capture mode while `pending` is high drops the pending value without committing it.
- R12: `mode` = 2'b11 behaves exactly as output compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | SEL_W | Byte lane of the write (1 = high byte) |
| wr_data | input | BUS_W | Byte written |
| mode | input | 2 | Channel mode: 00 capture, 01 compare, 10 edge PWM, 11 compare |
| clk_on | input | 1 | Timer clock source enabled |
| presc_tick | input | 1 | Counter advance strobe (end of prescale count) |
| ovf_tick | input | 1 | Counter wrap from modulo to zero |
| cap_evt | input | 1 | Input capture event |
| cnt_val | input | VAL_W | Current counter value |
| ctrl_wr | input | 1 | Channel status/control write strobe |
| val | output | VAL_W | Active register value (readback) |
| pending | output | 1 | Completed pair waiting for its commit point |

## Verification
The bench builds the block with its defaults: VAL_W = 16 and BUS_W = 8. That gives two byte lanes and a one-bit lane select. With so few lanes, a sweep can cover every mode encoding, both clock states and both byte orders, and count out each commit edge arithmetically. Directed sequences then cover the races between a commit point and a cancel, a new byte write, a clock stop or a mode change within one cycle.

// File: rtl/tcv_pkg.sv
package tcv_pkg;

  typedef enum logic [1:0] {
    CH_CAPTURE     = 2'b00,
    CH_COMPARE     = 2'b01,
    CH_EDGE_PWM    = 2'b10,
    CH_COMPARE_ALT = 2'b11
  } ch_mode_e;

  function automatic logic mode_is_capture(ch_mode_e m);
    return m == CH_CAPTURE;
  endfunction

  function automatic logic mode_waits_period(ch_mode_e m);
    return m == CH_EDGE_PWM;
  endfunction

endpackage

// File: rtl/tcv_wbuf.sv
module tcv_wbuf #(
  parameter int VAL_W = 16,
  parameter int BUS_W = 8,
  localparam int NBYTE = VAL_W / BUS_W,
  localparam int SEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SEL_W-1:0] sel,
  input  logic [BUS_W-1:0] data,
  input  logic             discard,
  output logic [VAL_W-1:0] merged,
  output logic             full
);

  logic [NBYTE-1:0] got_q, got_d, sel_oh;
  logic [VAL_W-1:0] buf_q, buf_d;

  always_comb begin
    sel_oh = '0;
    if (accept) sel_oh[sel] = 1'b1;
  end

  // A pair completes when this write fills the last empty lane
  assign full = accept && (&(got_q | sel_oh));

  always_comb begin
    if (discard || full) got_d = '0;
    else                 got_d = got_q | sel_oh;
  end

  for (genvar i = 0; i < NBYTE; i++) begin : g_lane
    assign buf_d[i*BUS_W +: BUS_W] =
      (accept && (sel == SEL_W'(i))) ? data : buf_q[i*BUS_W +: BUS_W];
  end

  assign merged = buf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= '0;
      buf_q <= '0;
    end else begin
      got_q <= got_d;
      if (accept) buf_q <= buf_d;
    end
  end

endmodule

// File: rtl/tcv_commit.sv
module tcv_commit
  import tcv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ch_mode_e mode,
  input  logic     clk_on,
  input  logic     presc_tick,
  input  logic     ovf_tick,
  input  logic     full,
  input  logic     byte_wr,
  input  logic     cancel,
  output logic     pending,
  output logic     commit
);

  logic pend_q, pend_d;
  logic tick, due;

  always_comb begin
    tick = mode_waits_period(mode) ? ovf_tick : presc_tick;
    due  = pend_q && (!clk_on || tick);
  end

  always_comb begin
    pend_d = pend_q;
    commit = 1'b0;
    if (cancel || mode_is_capture(mode)) begin
      pend_d = 1'b0;
    end else if (full) begin
      commit = !clk_on;
      pend_d = clk_on;
    end else if (byte_wr) begin
      pend_d = 1'b0;
    end else if (due) begin
      commit = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

endmodule

// File: rtl/tcv_active.sv
module tcv_active #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  input  logic             capture,
  input  logic [VAL_W-1:0] cnt_val,
  output logic [VAL_W-1:0] val
);

  logic [VAL_W-1:0] val_q, val_d;
  logic             val_en;

  always_comb begin
    val_en = load || capture;
    if (load)         val_d = load_val;
    else if (capture) val_d = cnt_val;
    else              val_d = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign val = val_q;

endmodule

// File: rtl/tmr_chan_value.sv
module tmr_chan_value
  import tcv_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int BUS_W = 8,
  localparam int NBYTE = VAL_W / BUS_W,
  localparam int SEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       mode,
  input  logic             clk_on,
  input  logic             presc_tick,
  input  logic             ovf_tick,
  input  logic             cap_evt,
  input  logic [VAL_W-1:0] cnt_val,
  input  logic             ctrl_wr,
  output logic [VAL_W-1:0] val,
  output logic             pending
);

  ch_mode_e         mode_e;
  logic             accept;
  logic             full;
  logic             commit;
  logic             capture;
  logic [VAL_W-1:0] merged;

  assign mode_e  = ch_mode_e'(mode);
  assign accept  = wr_en && !mode_is_capture(mode_e);
  assign capture = cap_evt && mode_is_capture(mode_e);

  tcv_wbuf #(.VAL_W(VAL_W), .BUS_W(BUS_W)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .sel     (wr_sel),
    .data    (wr_data),
    .discard (ctrl_wr),
    .merged  (merged),
    .full    (full)
  );

  tcv_commit u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_e),
    .clk_on     (clk_on),
    .presc_tick (presc_tick),
    .ovf_tick   (ovf_tick),
    .full       (full),
    .byte_wr    (accept),
    .cancel     (ctrl_wr),
    .pending    (pending),
    .commit     (commit)
  );

  tcv_active #(.VAL_W(VAL_W)) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (commit),
    .load_val (merged),
    .capture  (capture),
    .cnt_val  (cnt_val),
    .val      (val)
  );

endmodule

// File: rtl/tcv_chk.sv
module tcv_chk #(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       mode,
  input logic             clk_on,
  input logic             presc_tick,
  input logic             ovf_tick,
  input logic             cap_evt,
  input logic [VAL_W-1:0] cnt_val,
  input logic             ctrl_wr,
  input logic [VAL_W-1:0] val,
  input logic             pending
);

  // R2
  ic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !cap_evt) |=> $stable(val));

  // R3
  ic_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && cap_evt) |=> (val == $past(cnt_val)));

  // R4
  clk_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> !pending);

  // R5
  oc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && clk_on && pending && !presc_tick && !wr_en && !ctrl_wr)
      |=> (pending && $stable(val)));

  // R6
  pwm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && clk_on && pending && !ovf_tick && !wr_en && !ctrl_wr)
      |=> (pending && $stable(val)));

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !pending);

  // R11
  ic_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !pending);

endmodule

bind tmr_chan_value tcv_chk #(.VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .mode       (mode),
  .clk_on     (clk_on),
  .presc_tick (presc_tick),
  .ovf_tick   (ovf_tick),
  .cap_evt    (cap_evt),
  .cnt_val    (cnt_val),
  .ctrl_wr    (ctrl_wr),
  .val        (val),
  .pending    (pending)
);

// File: tb/tmr_chan_value_test.sv
module tmr_chan_value_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [0:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [1:0]  mode;
  logic        clk_on;
  logic        presc_tick;
  logic        ovf_tick;
  logic        cap_evt;
  logic [15:0] cnt_val;
  logic        ctrl_wr;
  logic [15:0] val;
  logic        pending;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 0;

  tmr_chan_value uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode(mode), .clk_on(clk_on), .presc_tick(presc_tick), .ovf_tick(ovf_tick),
    .cap_evt(cap_evt), .cnt_val(cnt_val), .ctrl_wr(ctrl_wr), .val(val),
    .pending(pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: val got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: pending got %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic w, input logic s, input logic [7:0] d,
                      input logic cw, input logic pt, input logic ot, input logic ce);
    wr_en = w; wr_sel = s; wr_data = d; ctrl_wr = cw;
    presc_tick = pt; ovf_tick = ot; cap_evt = ce;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; ctrl_wr = 0; presc_tick = 0; ovf_tick = 0; cap_evt = 0;
  endtask

  task automatic wbyte(input logic s, input logic [7:0] d);
    step(1'b1, s, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    string tag;
    wr_en = 0; wr_sel = 0; wr_data = 0; mode = 2'b01; clk_on = 0;
    presc_tick = 0; ovf_tick = 0; cap_evt = 0; cnt_val = 0; ctrl_wr = 0;
    rst_n = 1'b1;
    do_reset();
    chk16("R1", val, 16'h0000);
    chk1("R1", pending, 1'b0);

    // Sweep: every mode code, both clock states, both byte orders
    for (int m = 0; m < 4; m++) begin
      for (int ck = 0; ck < 2; ck++) begin
        for (int ord = 0; ord < 2; ord++) begin
          do_reset();
          mode = m[1:0];
          clk_on = ck[0];
          v = 16'h3C01 + 16'(m * 16'h1111) + (ck != 0 ? 16'h0050 : 16'h0000) + 16'(ord * 3);
          wbyte(ord[0], ord != 0 ? v[15:8] : v[7:0]);
          chk1("R7", pending, 1'b0);
          wbyte(!ord[0], ord != 0 ? v[7:0] : v[15:8]);
          if (m == 0) begin
            chk16("R2", val, 16'h0000);
            chk1("R2", pending, 1'b0);
          end else if (ck == 0) begin
            chk16("R4", val, v);
            chk1("R4", pending, 1'b0);
          end else begin
            tag = (m == 2) ? "R6" : (m == 3) ? "R12" : "R5";
            chk1(tag, pending, 1'b1);
            chk16(tag, val, 16'h0000);
            if (m == 2) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
            else        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
            chk1(tag, pending, 1'b1);
            chk16(tag, val, 16'h0000);
            if (m == 2) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
            else        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
            chk16(tag, val, v);
            chk1(tag, pending, 1'b0);
          end
        end
      end
    end

    // R7: rewriting one lane does not complete a pair
    do_reset();
    mode = 2'b01; clk_on = 1'b1;
    wbyte(1'b1, 8'h12);
    wbyte(1'b1, 8'h34);
    chk1("R7", pending, 1'b0);
    wbyte(1'b0, 8'h56);
    chk1("R7", pending, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk16("R7", val, 16'h3456);

    // R8: cancel beats a tick and discards collected bytes
    wbyte(1'b1, 8'hAB);
    wbyte(1'b0, 8'hCD);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    chk1("R8", pending, 1'b0);
    chk16("R8", val, 16'h3456);
    wbyte(1'b0, 8'hEF);
    chk1("R8", pending, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk16("R8", val, 16'h3456);
    wbyte(1'b1, 8'h77);
    chk1("R7", pending, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk16("R7", val, 16'h77EF);

    // R9: new byte while pending withdraws it, even against a tick
    wbyte(1'b1, 8'h11);
    wbyte(1'b0, 8'h22);
    step(1'b1, 1'b1, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0);
    chk1("R9", pending, 1'b0);
    chk16("R9", val, 16'h77EF);
    wbyte(1'b0, 8'h88);
    chk1("R9", pending, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk16("R9", val, 16'h9988);

    // R10: stopping the clock commits a pending value
    wbyte(1'b1, 8'h5A);
    wbyte(1'b0, 8'hA5);
    clk_on = 1'b0;
    idle();
    chk16("R10", val, 16'h5AA5);
    chk1("R10", pending, 1'b0);
    clk_on = 1'b1;

    // R11: switching to capture drops a pending value
    wbyte(1'b1, 8'h01);
    wbyte(1'b0, 8'h02);
    mode = 2'b00;
    idle();
    chk1("R11", pending, 1'b0);
    chk16("R11", val, 16'h5AA5);
    mode = 2'b01;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk16("R11", val, 16'h5AA5);

    // R3: capture loads the counter only in capture mode
    mode = 2'b00;
    for (int i = 0; i < 8; i++) begin
      cnt_val = 16'(i * 16'h2345 + 7);
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
      chk16("R3", val, 16'(i * 16'h2345 + 7));
    end
    cnt_val = 16'hFFFF;
    idle();
    chk16("R3", val, 16'(7 * 16'h2345 + 7));
    mode = 2'b01;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    chk16("R3", val, 16'(7 * 16'h2345 + 7));

    // R2: a byte written in capture mode is not kept
    do_reset();
    mode = 2'b00;
    wbyte(1'b1, 8'h44);
    chk16("R2", val, 16'h0000);
    mode = 2'b01; clk_on = 1'b0;
    wbyte(1'b0, 8'h55);
    chk16("R2", val, 16'h0000);
    chk1("R2", pending, 1'b0);
    wbyte(1'b1, 8'h66);
    chk16("R4", val, 16'h6655);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule